// File: doc/BRIEF.md
# EEPROM Page-Write Sequencer

This block sits between a simple memory bus and a 2-KB data EEPROM. The EEPROM is organised as 16 rows of 128 bytes. When the page-load enable input is high, byte writes on the bus do not reach the array. Each one lands in a 128-entry bank of column latches, and each latch carries a "written" flag. The row address of the most recent latch write is kept as the target row.

Software launches programming by writing the control register twice in a row. The first value has 5h in its upper nibble and the second has Ah. Any bus access between the two cancels the request. Idle cycles between them do not.

While programming runs, the block raises a busy output for a fixed, parameterised number of clock cycles. During that time it answers reads with FFh and ignores latch writes and commands. When the delay ends, every flagged latch is copied into the target row and all flags are cleared. Bytes that were not flagged keep their old array contents. The cell array is a behavioural model whose erased value is FFh.

Top module: `eeprom_page_seq`

## Requirements
- R1: After reset, busy is 0, mem_rdata is 00h and every array byte reads FFh.
- R2: A write with page_en=1 and busy=0 stores the byte in the latch selected by address bits [6:0] and sets its flag. The array, and so reads, are unchanged until a programming cycle completes.
- R3: A write with page_en=0 has no effect on latches, flags, target row or array.
- R4: A control write whose upper nibble is Ah, following a control write whose upper nibble is 5h with no bus access in between, raises busy on the next clock edge. Busy then stays high for exactly PROG_CYCLES cycles.
- R5: Between the 5h and Ah writes, any mem_rd, any mem_wr, or any control write with a different upper nibble cancels the launch. A control write with a 5h upper nibble re-arms instead. Idle cycles do not cancel.
- R6: At completion, only flagged latches are written into the target row. Unflagged bytes of that row keep their value.
- R7: The target row is address bits [10:7] of the last accepted latch write. Flagged data from earlier rows is written into that row.
- R8: All flags are cleared at completion, so a later launch with no new latch writes leaves the array unchanged.
- R9: While busy, a read returns FFh one cycle later. Latch writes and control writes are ignored.
- R10: A read returns the array byte at row address[10:7], column address[6:0], one cycle after mem_rd.
- R11: A single session can program any number of bytes from 1 to 128, including a full page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_en | input | 1 | Routes bus writes into the column latches when high |
| mem_wr | input | 1 | Bus write strobe |
| mem_rd | input | 1 | Bus read strobe |
| mem_addr | input | 11 | Byte address: [10:7] row, [6:0] column |
| mem_wdata | input | 8 | Bus write data |
| mem_rdata | output | 8 | Read data, valid the cycle after mem_rd |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register value; the upper nibble is the command |
| busy | output | 1 | High while a row is being programmed |

## Verification
A wrong flag bit shows up as a byte that changes or fails to change. A wrong target row shows up as data in the wrong row. Neither is visible until the completion edge and a later read. The bench therefore reads back every touched byte and its neighbours after each session. A wrong unlock state shows up at once: busy appears, or fails to appear, one cycle after the Ah write. A wrong delay count shows up as a busy pulse of the wrong length. Both are compared against a behavioural model on every clock.

// File: rtl/eeps_pkg.sv
package eeps_pkg;
  localparam logic [3:0] ARM_NIBBLE  = 4'h5;
  localparam logic [3:0] FIRE_NIBBLE = 4'hA;
  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  typedef enum logic [1:0] {CMD_OTHER, CMD_ARM, CMD_FIRE} cmd_kind_t;

  function automatic cmd_kind_t decode_cmd(input logic [7:0] value);
    if (value[7:4] == ARM_NIBBLE)       return CMD_ARM;
    else if (value[7:4] == FIRE_NIBBLE) return CMD_FIRE;
    else                                return CMD_OTHER;
  endfunction
endpackage

// File: rtl/eeps_unlock.sv
module eeps_unlock
  import eeps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  input  logic       bus_touch,
  input  logic       busy,
  output logic       armed,
  output logic       launch
);
  cmd_kind_t kind;
  logic      clean_cmd;

  assign kind      = decode_cmd(ctl_wdata);
  assign clean_cmd = ctl_wr && !bus_touch;
  assign launch    = clean_cmd && !busy && armed && (kind == CMD_FIRE);

  always_ff @(posedge clk) begin
    if (!rst_n)                  armed <= 1'b0;
    else if (busy)               armed <= 1'b0;
    else if (clean_cmd)          armed <= (kind == CMD_ARM);
    else if (ctl_wr || bus_touch) armed <= 1'b0;
  end
endmodule

// File: rtl/eeps_prog_timer.sv
module eeps_prog_timer #(
  parameter int PROG_CYCLES = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  logic [CW-1:0] left;

  assign done = busy && (left == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      left <= '0;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      left <= left - 1'b1;
    end else if (start) begin
      busy <= 1'b1;
      left <= CW'(PROG_CYCLES - 1);
    end
  end
endmodule

// File: rtl/eeps_latch_bank.sv
module eeps_latch_bank #(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 7,
  parameter int DATA_W   = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr,
  input  logic [ROW_BITS+COL_BITS-1:0]   addr,
  input  logic [DATA_W-1:0]              wdata,
  input  logic                           clr,
  output logic [(1<<COL_BITS)-1:0][DATA_W-1:0] data,
  output logic [(1<<COL_BITS)-1:0]       flags,
  output logic [ROW_BITS-1:0]            row
);
  localparam int COLS = 1 << COL_BITS;
  logic [COL_BITS-1:0] col;

  assign col = addr[COL_BITS-1:0];

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic hit;
    assign hit = wr && (col == COL_BITS'(c));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        data[c]  <= '0;
        flags[c] <= 1'b0;
      end else if (clr) begin
        flags[c] <= 1'b0;
      end else if (hit) begin
        data[c]  <= wdata;
        flags[c] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  row <= '0;
    else if (wr) row <= addr[ROW_BITS+COL_BITS-1:COL_BITS];
  end
endmodule

// File: rtl/eeps_array.sv
module eeps_array
  import eeps_pkg::*;
#(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 7,
  parameter int DATA_W   = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           commit,
  input  logic [ROW_BITS-1:0]            row,
  input  logic [(1<<COL_BITS)-1:0][DATA_W-1:0] data,
  input  logic [(1<<COL_BITS)-1:0]       flags,
  input  logic                           rd,
  input  logic [ROW_BITS+COL_BITS-1:0]   addr,
  input  logic                           busy,
  output logic [DATA_W-1:0]              rdata
);
  localparam int COLS  = 1 << COL_BITS;
  localparam int DEPTH = 1 << (ROW_BITS + COL_BITS);

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= DATA_W'(ERASED_BYTE);
      rdata <= '0;
    end else begin
      if (commit) begin
        for (int c = 0; c < COLS; c++)
          if (flags[c]) cells[{row, COL_BITS'(c)}] <= data[c];
      end
      if (rd) rdata <= busy ? DATA_W'(ERASED_BYTE) : cells[addr];
    end
  end
endmodule

// File: rtl/eeprom_page_seq.sv
module eeprom_page_seq #(
  parameter int ROW_BITS    = 4,
  parameter int COL_BITS    = 7,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 4000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         page_en,
  input  logic                         mem_wr,
  input  logic                         mem_rd,
  input  logic [ROW_BITS+COL_BITS-1:0] mem_addr,
  input  logic [DATA_W-1:0]            mem_wdata,
  output logic [DATA_W-1:0]            mem_rdata,
  input  logic                         ctl_wr,
  input  logic [7:0]                   ctl_wdata,
  output logic                         busy
);
  localparam int COLS = 1 << COL_BITS;

  logic                         bus_touch;
  logic                         latch_wr;
  logic                         armed;
  logic                         launch;
  logic                         done;
  logic [COLS-1:0][DATA_W-1:0]  lat_data;
  logic [COLS-1:0]              lat_flags;
  logic [ROW_BITS-1:0]          tgt_row;

  assign bus_touch = mem_wr || mem_rd;
  assign latch_wr  = mem_wr && page_en && !busy;

  eeps_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .bus_touch(bus_touch), .busy(busy), .armed(armed), .launch(launch)
  );

  eeps_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(launch), .busy(busy), .done(done)
  );

  eeps_latch_bank #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr(latch_wr), .addr(mem_addr), .wdata(mem_wdata),
    .clr(done), .data(lat_data), .flags(lat_flags), .row(tgt_row)
  );

  eeps_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n), .commit(done), .row(tgt_row), .data(lat_data),
    .flags(lat_flags), .rd(mem_rd), .addr(mem_addr), .busy(busy), .rdata(mem_rdata)
  );
endmodule

// File: rtl/eeps_checker.sv
module eeps_checker #(
  parameter int COLS        = 128,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 4000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              launch,
  input logic              done,
  input logic              armed,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [COLS-1:0]   lat_flags
);
  int busy_len;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  p_launch_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == PROG_CYCLES);

  p_access_disarms_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |=> !armed);

  p_flags_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> lat_flags == '0);

  p_read_busy_ff_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && busy) |=> mem_rdata == {DATA_W{1'b1}});

  p_flags_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(lat_flags));
endmodule

bind eeprom_page_seq eeps_checker #(.COLS(COLS), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .launch(launch), .done(done), .armed(armed),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata), .lat_flags(lat_flags)
);

// File: tb/sim_eeprom_page_seq.sv
`timescale 1ns/1ps
module sim_eeprom_page_seq;
  localparam int PROG = 12;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        page_en = 0, mem_wr = 0, mem_rd = 0, ctl_wr = 0;
  logic [10:0] mem_addr = '0;
  logic [7:0]  mem_wdata = '0, ctl_wdata = '0;
  logic [7:0]  mem_rdata;
  logic        busy;

  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  eeprom_page_seq #(.PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .page_en(page_en), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .busy(busy)
  );

  // behavioural reference model
  byte unsigned m_mem [2048];
  byte unsigned m_lat [128];
  bit           m_flag [128];
  int           m_pending [$];
  int           m_row, m_left;
  bit           m_busy, m_armed;
  byte unsigned m_rdata;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 8'hFF;
      foreach (m_flag[i]) m_flag[i] = 0;
      m_pending.delete();
      m_row = 0; m_left = 0; m_busy = 0; m_armed = 0; m_rdata = 0;
    end else begin
      bit was_busy, touch, fire;
      was_busy = m_busy;
      touch = mem_rd || mem_wr;
      if (mem_rd) m_rdata = was_busy ? 8'hFF : m_mem[mem_addr];
      if (was_busy) begin
        if (m_left == 1) begin
          while (m_pending.size() > 0) begin
            int c;
            c = m_pending.pop_front();
            m_mem[m_row*128 + c] = m_lat[c];
            m_flag[c] = 0;
          end
          m_busy = 0;
        end else m_left--;
      end
      fire = ctl_wr && !touch && !was_busy && m_armed && (ctl_wdata[7:4] == 4'hA);
      if (was_busy) m_armed = 0;
      else if (ctl_wr && !touch) m_armed = (ctl_wdata[7:4] == 4'h5);
      else if (ctl_wr || touch) m_armed = 0;
      if (fire) begin m_busy = 1; m_left = PROG; end
      if (mem_wr && page_en && !was_busy) begin
        int c;
        c = mem_addr % 128;
        m_lat[c] = mem_wdata;
        if (!m_flag[c]) m_pending.push_back(c);
        m_flag[c] = 1;
        m_row = mem_addr / 128;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(busy == m_busy, "R4 busy vs model", busy, m_busy);
      check(mem_rdata == m_rdata, "R10 rdata vs model", mem_rdata, m_rdata);
    end
  end

  function automatic logic [10:0] ad(input int row, input int col);
    return 11'(row * 128 + col);
  endfunction

  task automatic lwr(input logic [10:0] a, input logic [7:0] d);
    mem_wr = 1; mem_addr = a; mem_wdata = d;
    @(negedge clk);
    mem_wr = 0;
  endtask

  task automatic cmd(input logic [7:0] v);
    ctl_wr = 1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic rd(input logic [10:0] a, input logic [7:0] exp, input string req);
    mem_rd = 1; mem_addr = a;
    @(negedge clk);
    mem_rd = 0;
    check(mem_rdata == exp, req, mem_rdata, exp);
  endtask

  task automatic wait_done();
    while (busy) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R4 actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(busy == 0, "R1 busy after reset", busy, 0);
    check(mem_rdata == 0, "R1 rdata after reset", mem_rdata, 0);
    rd(ad(9, 35), 8'hFF, "R1 erased array");

    // R2 latch write not visible before programming
    page_en = 1;
    lwr(ad(3, 5), 8'hA5);
    lwr(ad(3, 6), 8'h5A);
    rd(ad(3, 5), 8'hFF, "R2 latched byte not in array");

    // R4 launch and busy length
    cmd(8'h50);
    cmd(8'hA0);
    check(busy == 1, "R4 busy after unlock", busy, 1);
    begin
      int n;
      n = 0;
      // R9 read and latch write during busy
      rd(ad(3, 5), 8'hFF, "R9 read while busy");
      n++;
      lwr(ad(3, 7), 8'h77);
      n++;
      cmd(8'h50);
      n++;
      while (busy) begin n++; @(negedge clk); end
      check(n == PROG, "R4 busy length", n, PROG);
    end
    rd(ad(3, 5), 8'hA5, "R6 flagged byte programmed");
    rd(ad(3, 6), 8'h5A, "R10 second flagged byte");
    rd(ad(3, 7), 8'hFF, "R9 latch write while busy ignored");
    rd(ad(2, 5), 8'hFF, "R10 other row untouched");
    rd(ad(3, 4), 8'hFF, "R6 unflagged byte kept");

    // R8 flags cleared: relaunch without writes leaves array
    cmd(8'h5C);
    cmd(8'hA3);
    check(busy == 1, "R8 relaunch busy", busy, 1);
    wait_done();
    rd(ad(3, 5), 8'hA5, "R8 array unchanged after empty launch");
    rd(ad(3, 7), 8'hFF, "R8 no stale flag on col 7");

    // R7 last page wins
    lwr(ad(1, 0), 8'h11);
    lwr(ad(2, 1), 8'h22);
    cmd(8'h50); cmd(8'hA0);
    wait_done();
    rd(ad(1, 0), 8'hFF, "R7 earlier row discarded");
    rd(ad(2, 0), 8'h11, "R7 earlier data into last row");
    rd(ad(2, 1), 8'h22, "R7 last row data");

    // R5 aborts
    lwr(ad(4, 0), 8'h44);
    cmd(8'h5F); rd(ad(0, 0), 8'hFF, "R5 read between"); cmd(8'hA0);
    check(busy == 0, "R5 read aborts", busy, 0);
    cmd(8'h53); lwr(ad(4, 1), 8'h45); cmd(8'hA0);
    check(busy == 0, "R5 write aborts", busy, 0);
    cmd(8'h53); cmd(8'h30); cmd(8'hA0);
    check(busy == 0, "R5 other command aborts", busy, 0);
    cmd(8'h51); repeat (3) @(negedge clk); cmd(8'hAF);
    check(busy == 1, "R5 idle cycles keep arm", busy, 1);
    wait_done();
    rd(ad(4, 0), 8'h44, "R5 launched data");
    rd(ad(4, 1), 8'h45, "R5 aborting write still latched");

    // R3 writes with page_en low ignored
    page_en = 0;
    lwr(ad(5, 9), 8'h99);
    page_en = 1;
    cmd(8'h50); cmd(8'hA0);
    wait_done();
    rd(ad(5, 9), 8'hFF, "R3 disabled write ignored");
    rd(ad(4, 9), 8'hFF, "R3 row not redirected");

    // R11 full page
    for (int c = 0; c < 128; c++) lwr(ad(6, c), 8'(c ^ 8'h6A));
    cmd(8'h5A); cmd(8'hA5);
    wait_done();
    for (int c = 0; c < 128; c++) rd(ad(6, c), 8'(c ^ 8'h6A), "R11 full page");
    rd(ad(7, 0), 8'hFF, "R11 next row untouched");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule